// File: doc/BRIEF.md
# Tag-Capturing Reservation Station Group

This block is the set of waiting slots in front of one functional unit of an out-of-order core. An issuing instruction is placed into a free slot together with its operation code and two source operands. Each source is either an actual value or the nonzero tag of the slot, anywhere in the machine, that will produce it. A tag of zero marks a value as present, so no separate ready bit is stored.

All slots watch one shared result bus. When the tag on the bus matches a waiting source tag, the slot takes the bus data and clears that tag. A slot whose two tags are both zero may be sent to the unit. Among several such slots, the one that was issued first goes first. The unit takes one dispatch per handshake. When the unit reports completion, the block shows the result with the slot's tag for broadcast on the next cycle and makes the slot available again.

Slot tags are `BASE_TAG + index`. They are nonzero and unique across the machine, and the default is three slots.

Top module: `rs_group`

## Requirements
- R1: After reset, no slot is occupied: `iss_ready` is 1, `disp_valid` is 0 and `res_valid` is 0.
- R2: An accepted issue (`iss_valid` and `iss_ready`) fills the lowest-numbered free slot, whose tag is `BASE_TAG` plus its index. A slot freed by completion is used again.
- R3: When every slot is occupied, `iss_ready` is 0 and an issue attempt changes no slot. The attempted operation is never dispatched.
- R4: A slot with a nonzero source tag is not dispatched.
- R5: In a cycle with `bus_valid` set, a waiting source whose tag equals `bus_tag` takes `bus_data` and its tag becomes zero. A source with a different tag is unchanged.
- R6: If the bus carries a source's tag in the same cycle that source is issued, the slot stores the bus value instead of the tag and can be dispatched on the next cycle.
- R7: When several slots are ready, the earliest-issued one is presented on the dispatch port, whatever its index.
- R8: A dispatch takes place when `disp_valid` and `disp_ready` are both high. The dispatched slot is never presented again while it stays occupied.
- R9: `done_valid` with a dispatched slot's tag frees that slot. On the next cycle, `res_valid` is 1, `res_tag` is that tag and `res_data` is `done_data`.
- R10: A matching `bus_tag` while `bus_valid` is 0 captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Operation code to store |
| iss_src1_tag | input | 4 | Producer tag of source 1, 0 when value given |
| iss_src1_val | input | 64 | Value of source 1 |
| iss_src2_tag | input | 4 | Producer tag of source 2, 0 when value given |
| iss_src2_val | input | 64 | Value of source 2 |
| iss_ready | output | 1 | At least one slot is free |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | 4 | Tag of the producing slot |
| bus_data | input | 64 | Result value on the bus |
| disp_valid | output | 1 | A ready slot is presented to the unit |
| disp_ready | input | 1 | Unit accepts the presented slot |
| disp_op | output | 4 | Operation of the presented slot |
| disp_a | output | 64 | Source 1 value of the presented slot |
| disp_b | output | 64 | Source 2 value of the presented slot |
| disp_tag | output | 4 | Tag of the presented slot |
| done_valid | input | 1 | Unit finished an operation |
| done_tag | input | 4 | Tag of the finished slot |
| done_data | input | 64 | Result of the finished operation |
| res_valid | output | 1 | Result ready for broadcast |
| res_tag | output | 4 | Tag of the result |
| res_data | output | 64 | Result value |

## Verification
The hardest case to reach is an age-ordering decision in which a younger slot with a lower index is ready at the same time as older slots with higher indices. The stimulus first fills slot 0 with a ready operation and slots 1 and 2 with operations that wait on one external tag. It then retires slot 0 and refills it, and in that same cycle broadcasts the tag that releases slots 1 and 2. This makes three slots ready in one cycle with age opposite to index order. The same-cycle capture during issue is produced by driving the bus and the issue port together.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DATA_W = 64;
    localparam int TAG_W  = 4;
    localparam int OP_W   = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef struct packed {
        tag_t  q;
        data_t v;
    } src_t;

    typedef struct packed {
        logic  busy;
        logic  exec;
        op_t   op;
        tag_t  qj;
        tag_t  qk;
        data_t vj;
        data_t vk;
    } slot_t;

    // Resolve an issuing source: a given value, a same-cycle bus hit, or a pending tag.
    function automatic src_t resolve_src(input tag_t t, input data_t v,
                                         input logic bv, input tag_t bt, input data_t bd);
        src_t s;
        if (t == '0) begin
            s.q = '0;
            s.v = v;
        end else if (bv && bt == t) begin
            s.q = '0;
            s.v = bd;
        end else begin
            s.q = t;
            s.v = '0;
        end
        return s;
    endfunction
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int N = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     free_vec,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);
    always_comb begin
        any_free = |free_vec;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        ready_vec,
    input  logic [N-1:0][N-1:0] older,
    output logic                any_ready,
    output logic [IDX_W-1:0]    pick_idx
);
    logic [N-1:0] oldest;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            oldest[i] = ready_vec[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && ready_vec[j] && older[j][i]) oldest[i] = 1'b0;
            end
        end
        any_ready = |ready_vec;
        pick_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (oldest[i]) pick_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rs_group.sv
module rs_group
    import rs_pkg::*;
#(
    parameter int NUM_RS   = 3,
    parameter int BASE_TAG = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [OP_W-1:0]      iss_op,
    input  logic [TAG_W-1:0]     iss_src1_tag,
    input  logic [DATA_W-1:0]    iss_src1_val,
    input  logic [TAG_W-1:0]     iss_src2_tag,
    input  logic [DATA_W-1:0]    iss_src2_val,
    output logic                 iss_ready,
    input  logic                 bus_valid,
    input  logic [TAG_W-1:0]     bus_tag,
    input  logic [DATA_W-1:0]    bus_data,
    output logic                 disp_valid,
    input  logic                 disp_ready,
    output logic [OP_W-1:0]      disp_op,
    output logic [DATA_W-1:0]    disp_a,
    output logic [DATA_W-1:0]    disp_b,
    output logic [TAG_W-1:0]     disp_tag,
    input  logic                 done_valid,
    input  logic [TAG_W-1:0]     done_tag,
    input  logic [DATA_W-1:0]    done_data,
    output logic                 res_valid,
    output logic [TAG_W-1:0]     res_tag,
    output logic [DATA_W-1:0]    res_data
);
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    typedef struct packed {
        slot_t [NUM_RS-1:0]              slot;
        logic  [NUM_RS-1:0][NUM_RS-1:0]  older;
        logic                            res_valid;
        tag_t                            res_tag;
        data_t                           res_data;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_RS-1:0] busy_vec, free_vec, ready_vec;
    logic              any_free, any_ready, iss_fire, disp_fire;
    logic [IDX_W-1:0]  free_idx, disp_idx;
    src_t              src1, src2;

    for (genvar g = 0; g < NUM_RS; g++) begin : g_flags
        assign busy_vec[g]  = st_q.slot[g].busy;
        assign free_vec[g]  = ~st_q.slot[g].busy;
        assign ready_vec[g] = st_q.slot[g].busy && !st_q.slot[g].exec &&
                              st_q.slot[g].qj == '0 && st_q.slot[g].qk == '0;
    end

    rs_free_pick #(.N(NUM_RS)) i_free_pick (
        .free_vec (free_vec),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    rs_age_pick #(.N(NUM_RS)) i_age_pick (
        .ready_vec (ready_vec),
        .older     (st_q.older),
        .any_ready (any_ready),
        .pick_idx  (disp_idx)
    );

    assign iss_fire  = iss_valid && any_free;
    assign disp_fire = any_ready && disp_ready;
    assign src1 = resolve_src(iss_src1_tag, iss_src1_val, bus_valid, bus_tag, bus_data);
    assign src2 = resolve_src(iss_src2_tag, iss_src2_val, bus_valid, bus_tag, bus_data);

    always_comb begin
        st_d = st_q;
        st_d.res_valid = done_valid;
        if (done_valid) begin
            st_d.res_tag  = done_tag;
            st_d.res_data = done_data;
        end
        for (int i = 0; i < NUM_RS; i++) begin
            if (st_q.slot[i].busy && bus_valid) begin
                if (st_q.slot[i].qj != '0 && st_q.slot[i].qj == bus_tag) begin
                    st_d.slot[i].vj = bus_data;
                    st_d.slot[i].qj = '0;
                end
                if (st_q.slot[i].qk != '0 && st_q.slot[i].qk == bus_tag) begin
                    st_d.slot[i].vk = bus_data;
                    st_d.slot[i].qk = '0;
                end
            end
            if (disp_fire && disp_idx == IDX_W'(i)) st_d.slot[i].exec = 1'b1;
            if (done_valid && st_q.slot[i].busy && st_q.slot[i].exec &&
                done_tag == tag_t'(BASE_TAG + i)) begin
                st_d.slot[i].busy = 1'b0;
                st_d.slot[i].exec = 1'b0;
            end
        end
        if (iss_fire) begin
            st_d.slot[free_idx].busy = 1'b1;
            st_d.slot[free_idx].exec = 1'b0;
            st_d.slot[free_idx].op   = iss_op;
            st_d.slot[free_idx].qj   = src1.q;
            st_d.slot[free_idx].vj   = src1.v;
            st_d.slot[free_idx].qk   = src2.q;
            st_d.slot[free_idx].vk   = src2.v;
            for (int j = 0; j < NUM_RS; j++) begin
                st_d.older[j][free_idx] = busy_vec[j];
                st_d.older[free_idx][j] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_ready  = any_free;
    assign disp_valid = any_ready;
    assign disp_op    = st_q.slot[disp_idx].op;
    assign disp_a     = st_q.slot[disp_idx].vj;
    assign disp_b     = st_q.slot[disp_idx].vk;
    assign disp_tag   = tag_t'(BASE_TAG) + tag_t'(disp_idx);
    assign res_valid  = st_q.res_valid;
    assign res_tag    = st_q.res_tag;
    assign res_data   = st_q.res_data;
endmodule

// File: rtl/rs_group_chk.sv
module rs_group_chk
    import rs_pkg::*;
#(
    parameter int NUM_RS   = 3,
    parameter int BASE_TAG = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [TAG_W-1:0]  disp_tag,
    input logic              done_valid,
    input logic [TAG_W-1:0]  done_tag,
    input logic              res_valid,
    input logic [TAG_W-1:0]  res_tag,
    input logic [NUM_RS-1:0] busy_vec
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> iss_ready && !disp_valid && !res_valid);

    // R2
    issue_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && !done_valid |=>
            $countones(busy_vec) == $past($countones(busy_vec)) + 1);

    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !iss_ready && !done_valid |=> $countones(busy_vec) == NUM_RS);

    // R8
    disp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (int'(disp_tag) >= BASE_TAG) && (int'(disp_tag) < BASE_TAG + NUM_RS));

    // R8
    no_redispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready |=> !disp_valid || disp_tag != $past(disp_tag));

    // R9
    result_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> res_valid && res_tag == $past(done_tag));
endmodule

bind rs_group rs_group_chk #(.NUM_RS(NUM_RS), .BASE_TAG(BASE_TAG)) i_rs_group_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag   (disp_tag),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .res_valid  (res_valid),
    .res_tag    (res_tag),
    .busy_vec   (busy_vec)
);

// File: tb/test_rs_group.sv
`timescale 1ns/1ps
module test_rs_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic [3:0]  iss_src1_tag = '0;
    logic [63:0] iss_src1_val = '0;
    logic [3:0]  iss_src2_tag = '0;
    logic [63:0] iss_src2_val = '0;
    logic        iss_ready;
    logic        bus_valid = 1'b0;
    logic [3:0]  bus_tag = '0;
    logic [63:0] bus_data = '0;
    logic        disp_valid;
    logic        disp_ready = 1'b0;
    logic [3:0]  disp_op;
    logic [63:0] disp_a, disp_b;
    logic [3:0]  disp_tag;
    logic        done_valid = 1'b0;
    logic [3:0]  done_tag = '0;
    logic [63:0] done_data = '0;
    logic        res_valid;
    logic [3:0]  res_tag;
    logic [63:0] res_data;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    rs_group i_rs_group (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic put_issue(input logic [3:0] op, input logic [3:0] t1, input logic [63:0] v1,
                             input logic [3:0] t2, input logic [63:0] v2);
        iss_valid = 1'b1; iss_op = op;
        iss_src1_tag = t1; iss_src1_val = v1;
        iss_src2_tag = t2; iss_src2_val = v2;
    endtask

    task automatic finish_unit(input logic [3:0] tag, input logic [63:0] data);
        done_valid = 1'b1; done_tag = tag; done_data = data;
        tick;
        done_valid = 1'b0;
    endtask

    task automatic retire(input logic [3:0] tag);
        disp_ready = 1'b1;
        tick;
        disp_ready = 1'b0;
        finish_unit(tag, 64'h0);
    endtask

    task automatic t_reset;
        check("R1 iss_ready", iss_ready, 1);
        check("R1 disp_valid", disp_valid, 0);
        check("R1 res_valid", res_valid, 0);
    endtask

    task automatic t_basic;
        put_issue(4'h3, 0, 64'h1111, 0, 64'h2222);
        tick;
        iss_valid = 1'b0;
        check("R2 disp_valid", disp_valid, 1);
        check("R2 disp_tag", disp_tag, 1);
        check("R2 disp_op", disp_op, 3);
        check("R2 disp_a", disp_a, 64'h1111);
        check("R2 disp_b", disp_b, 64'h2222);
        disp_ready = 1'b1;
        tick;
        disp_ready = 1'b0;
        check("R8 no repeat", disp_valid, 0);
        finish_unit(4'd1, 64'hABCD_0001);
        check("R9 res_valid", res_valid, 1);
        check("R9 res_tag", res_tag, 1);
        check("R9 res_data", res_data, 64'hABCD_0001);
        check("R9 freed", iss_ready, 1);
        tick;
        check("R9 res drop", res_valid, 0);
    endtask

    task automatic t_wait_capture;
        put_issue(4'h5, 4'd7, 64'h0, 0, 64'h3333);
        tick;
        iss_valid = 1'b0;
        check("R4 waiting", disp_valid, 0);
        bus_valid = 1'b0; bus_tag = 4'd7; bus_data = 64'hDEAD;
        tick;
        check("R10 no capture", disp_valid, 0);
        bus_valid = 1'b1; bus_tag = 4'd6; bus_data = 64'hBEEF;
        tick;
        check("R5 other tag", disp_valid, 0);
        bus_tag = 4'd7; bus_data = 64'hC0FFEE;
        tick;
        bus_valid = 1'b0;
        check("R5 captured", disp_valid, 1);
        check("R5 value", disp_a, 64'hC0FFEE);
        check("R2 reused slot", disp_tag, 1);
        check("R5 other src", disp_b, 64'h3333);
        retire(4'd1);
        tick;
    endtask

    task automatic t_bypass;
        put_issue(4'h6, 0, 64'h4444, 4'd9, 64'h0);
        bus_valid = 1'b1; bus_tag = 4'd9; bus_data = 64'h5555;
        tick;
        iss_valid = 1'b0; bus_valid = 1'b0;
        check("R6 ready", disp_valid, 1);
        check("R6 value", disp_b, 64'h5555);
        check("R6 src1", disp_a, 64'h4444);
        retire(4'd1);
        tick;
    endtask

    task automatic t_order;
        put_issue(4'h1, 0, 64'h1, 0, 64'h1);
        tick;
        put_issue(4'h2, 4'd9, 64'h0, 0, 64'h2);
        tick;
        put_issue(4'h3, 0, 64'h3, 4'd9, 64'h0);
        tick;
        iss_valid = 1'b0;
        check("R7 only ready", disp_tag, 1);
        retire(4'd1);
        put_issue(4'hA, 0, 64'hA, 0, 64'hA);
        bus_valid = 1'b1; bus_tag = 4'd9; bus_data = 64'h99;
        tick;
        iss_valid = 1'b0; bus_valid = 1'b0;
        check("R7 oldest first", disp_tag, 2);
        check("R7 oldest op", disp_op, 2);
        disp_ready = 1'b1;
        tick;
        check("R7 second", disp_tag, 3);
        tick;
        check("R7 youngest", disp_tag, 1);
        check("R7 youngest op", disp_op, 4'hA);
        tick;
        disp_ready = 1'b0;
        check("R8 all sent", disp_valid, 0);
        finish_unit(4'd2, 64'h0);
        finish_unit(4'd3, 64'h0);
        finish_unit(4'd1, 64'h0);
        check("R9 all free", iss_ready, 1);
    endtask

    task automatic t_full;
        for (int k = 1; k <= 3; k++) begin
            put_issue(4'(k), 0, 64'(k), 0, 64'(k));
            tick;
        end
        iss_valid = 1'b0;
        check("R3 full", iss_ready, 0);
        put_issue(4'hF, 0, 64'hF, 0, 64'hF);
        tick;
        iss_valid = 1'b0;
        check("R3 still full", iss_ready, 0);
        check("R3 head op", disp_op, 1);
        disp_ready = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            check("R3 order op", disp_op, 64'(k));
            tick;
        end
        disp_ready = 1'b0;
        check("R3 no extra", disp_valid, 0);
        for (int k = 1; k <= 3; k++) finish_unit(4'(k), 64'h0);
        check("R3 drained", iss_ready, 1);
    endtask

    task automatic report;
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_basic;
        t_wait_capture;
        t_bypass;
        t_order;
        t_full;
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
    end
endmodule